// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Decision Timeout

This block runs the digital half of a successive-approximation converter. A start pulse begins a conversion. The block then makes one bit trial per result bit, most significant bit first. For each trial it drives a trial code onto the capacitor-array control bits and raises the comparator clock. It then waits until the comparator reports a decision. The comparator's two outputs both rest high while its clock is low. The block treats the moment either output drops as "decision made", and it takes the bit from which output dropped.

A comparator whose input difference is under one LSB can stay undecided for a long time. To bound this, a programmable count of system clocks limits how long the comparator clock may stay high. If the limit runs out before any decision, the trial ends anyway. The bit is then taken from a 7-bit pseudorandom sequence, because either value is within quantisation error in that case. When the last trial ends, the block registers the result word together with a sticky flag that records whether any trial was forced, and it pulses done.

Top module: `sar_timeout_ctrl`

## Requirements
- R1: While reset is held, and until the first start is accepted, `cmp_clk_o`, `done_o` and `tmo_flag_o` are low, and `result_o` and `dac_o` are zero.
- R2: A start pulse sampled while idle raises `cmp_clk_o` on the following clock. At that point `dac_o` holds only its top bit set.
- R3: A trial completes when either comparator output is low (the NAND of the two outputs). The decided bit is 1 when `cmp_n_i` is the low one and 0 when `cmp_p_i` is the low one.
- R4: During the trial for bit position i, `dac_o` carries the bits already decided above i, a 1 at position i, and zeros below i. The final result is the word of all decided bits.
- R5: Between consecutive trials, `cmp_clk_o` goes low for exactly one clock. Each conversion therefore shows exactly NBITS separate high phases.
- R6: With a nonzero limit L on `tmo_limit_i`, a trial that has not completed stays high for exactly L clocks and then ends by timeout. Its bit is taken from the pseudorandom sequence, and the conversion's timeout flag is set.
- R7: If completion and timeout arrive in the same clock, completion wins. The comparator bit is used and no timeout is recorded.
- R8: A limit of zero disables the timeout. A trial then lasts exactly as long as the comparator needs.
- R9: The pseudorandom bit is bit 6 of a 7-bit register with reset value 7'h01. On use, the register shifts left with bit 6 XOR bit 5 entering at bit 0. It advances only when a timed-out trial consumes its bit, and it carries over between conversions.
- R10: `done_o` is high for exactly one clock per conversion. `result_o` and `tmo_flag_o` update on the same edge that raises `done_o` and hold until the next done.
- R11: A start pulse that arrives while a conversion is running has no effect. That conversion completes with an unchanged result, and only one done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start pulse |
| cmp_p_i | input | 1 | Comparator output, falls low to decide a 0 |
| cmp_n_i | input | 1 | Comparator output, falls low to decide a 1 |
| tmo_limit_i | input | TMO_W | Maximum high clocks per trial; 0 disables the timeout |
| cmp_clk_o | output | 1 | Comparator clock: high means evaluate, low means reset |
| dac_o | output | NBITS | Capacitor-array control bits for the current trial |
| done_o | output | 1 | One-clock conversion-complete strobe |
| result_o | output | NBITS | Registered conversion result |
| tmo_flag_o | output | 1 | Set if any trial of the last conversion ended by timeout |

## Verification
The hardest situation to reach from the ports is a trial that ends on the very clock where the comparator also resolves, together with a mix of forced and decided trials within one conversion. The bench models the comparator with a per-trial resolution delay and a per-trial mask that keeps selected trials unresolved forever. Setting the delay equal to the limit drives the tie case. Masking scattered trials forces pseudorandom bits in the middle of an otherwise normal conversion. A bench copy of the sequence generator follows the state across conversions, and the measured high-phase lengths confirm which trials were cut short.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_GAP  = 2'd2
  } sar_state_e;

  localparam int PN_W      = 7;
  localparam int PN_TAP_HI = 6;
  localparam int PN_TAP_LO = 5;
  localparam logic [PN_W-1:0] PN_SEED = 7'h01;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sar_pn_gen.sv
module sar_pn_gen
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic bit_o
);

  logic [PN_W-1:0] lfsr_q;
  logic [PN_W-1:0] lfsr_d;
  logic            fb;

  assign fb = lfsr_q[PN_TAP_HI] ^ lfsr_q[PN_TAP_LO];

  always_comb begin
    lfsr_d = lfsr_q;
    if (adv_i) begin
      lfsr_d = {lfsr_q[PN_W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= PN_SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  assign bit_o = lfsr_q[PN_W-1];

  AST_PN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !adv_i |=> $stable(lfsr_q)); // R9
  AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0); // R9

endmodule

// File: rtl/sar_trial_timer.sv
module sar_trial_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  localparam int CW1 = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CW1-1:0]   cnt_inc;
  logic             limit_on;

  assign cnt_inc  = {1'b0, cnt_q} + CW1'(1);
  assign limit_on = (limit_i != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = run_i && limit_on && (cnt_inc >= {1'b0, limit_i});

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (!rst_n) (limit_i == '0) |-> !expired_o); // R8
  AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !run_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             complete_i,
  input  logic             cmp_bit_i,
  input  logic             expired_i,
  input  logic             pn_bit_i,
  output logic             cmp_clk_o,
  output logic             pn_adv_o,
  output logic [NBITS-1:0] dac_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o,
  output logic             tmo_flag_o
);

  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBITS - 1);
  localparam logic [NBITS-1:0] DAC_FIRST = {1'b1, {(NBITS-1){1'b0}}};

  sar_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NBITS-1:0] dac_q, dac_d;
  logic [NBITS-1:0] dac_trial;
  logic [NBITS-1:0] low_mask;
  logic             flag_q, flag_d;
  logic             done_q, done_d;
  logic [NBITS-1:0] result_q;
  logic             tflag_q;
  logic             trial_end;
  logic             use_pn;
  logic             bit_val;
  logic             last_trial;

  assign trial_end  = (state_q == ST_EVAL) && (complete_i || expired_i);
  assign use_pn     = !complete_i;
  assign bit_val    = complete_i ? cmp_bit_i : pn_bit_i;
  assign last_trial = (idx_q == '0);

  for (genvar j = 0; j < NBITS; j++) begin : g_bit
    if (j < NBITS - 1) begin : g_mid
      always_comb begin
        dac_trial[j] = dac_q[j];
        if (idx_q == IDX_W'(j)) begin
          dac_trial[j] = bit_val;
        end else if (idx_q == IDX_W'(j + 1)) begin
          dac_trial[j] = 1'b1;
        end
      end
    end else begin : g_top
      always_comb begin
        dac_trial[j] = dac_q[j];
        if (idx_q == IDX_W'(j)) begin
          dac_trial[j] = bit_val;
        end
      end
    end
    assign low_mask[j] = (IDX_W'(j) < idx_q);
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dac_d   = dac_q;
    flag_d  = flag_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_EVAL;
          idx_d   = IDX_TOP;
          dac_d   = DAC_FIRST;
          flag_d  = 1'b0;
        end
      end
      ST_EVAL: begin
        if (trial_end) begin
          dac_d  = dac_trial;
          flag_d = flag_q | use_pn;
          if (last_trial) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_GAP;
            idx_d   = idx_q - IDX_W'(1);
          end
        end
      end
      ST_GAP: begin
        state_d = ST_EVAL;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dac_q   <= '0;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dac_q   <= dac_d;
      flag_q  <= flag_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      tflag_q  <= 1'b0;
    end else if (done_d) begin
      result_q <= dac_d;
      tflag_q  <= flag_d;
    end
  end

  assign cmp_clk_o  = (state_q == ST_EVAL);
  assign pn_adv_o   = trial_end && use_pn;
  assign dac_o      = dac_q;
  assign done_o     = done_q;
  assign result_o   = result_q;
  assign tmo_flag_o = tflag_q;

  AST_CLK_GAP: assert property (@(posedge clk) disable iff (!rst_n) trial_end |=> !cmp_clk_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result_o) |-> done_o); // R10
  AST_TRIAL_CODE: assert property (@(posedge clk) disable iff (!rst_n) cmp_clk_o |-> (dac_q[idx_q] && ((dac_q & low_mask) == '0))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (cmp_clk_o && !trial_end && start_i) |=> $stable(dac_q)); // R11

endmodule

// File: rtl/sar_timeout_ctrl.sv
module sar_timeout_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 10,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_p_i,
  input  logic             cmp_n_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output logic             cmp_clk_o,
  output logic [NBITS-1:0] dac_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o,
  output logic             tmo_flag_o
);

  logic rst_core_n;
  logic complete;
  logic cmp_bit;
  logic expired;
  logic pn_bit;
  logic pn_adv;
  logic eval_on;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  assign complete = ~(cmp_p_i & cmp_n_i);
  assign cmp_bit  = ~cmp_n_i;

  sar_trial_timer #(.CNT_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run_i    (eval_on),
    .limit_i  (tmo_limit_i),
    .expired_o(expired)
  );

  sar_pn_gen u_pn (
    .clk  (clk),
    .rst_n(rst_core_n),
    .adv_i(pn_adv),
    .bit_o(pn_bit)
  );

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start_i   (start_i),
    .complete_i(complete),
    .cmp_bit_i (cmp_bit),
    .expired_i (expired),
    .pn_bit_i  (pn_bit),
    .cmp_clk_o (eval_on),
    .pn_adv_o  (pn_adv),
    .dac_o     (dac_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .tmo_flag_o(tmo_flag_o)
  );

  assign cmp_clk_o = eval_on;

  AST_COMPLETE_WINS: assert property (@(posedge clk) disable iff (!rst_core_n) (eval_on && complete) |-> !pn_adv); // R7
  AST_PN_ONLY_EVAL: assert property (@(posedge clk) disable iff (!rst_core_n) pn_adv |-> (eval_on && expired)); // R6

endmodule

// File: tb/tb_sar_timeout_ctrl.sv
module tb_sar_timeout_ctrl;

  localparam int CLK_P = 10;
  localparam int NB    = 10;
  localparam int TW    = 8;

  typedef struct {
    logic [NB-1:0] res;
    logic          flg;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cmp_p = 1'b1;
  logic          cmp_n = 1'b1;
  logic [TW-1:0] limit = '0;
  logic          cmp_clk;
  logic [NB-1:0] dac;
  logic          done;
  logic [NB-1:0] result;
  logic          tflag;

  int total = 0;
  int bad = 0;
  int vin = 0;
  int dly_base = 1;
  logic [NB-1:0] stuck = '0;
  int hicnt = 0;
  int ph = 0;
  int cur = 0;
  int hl [NB];
  int ndone = 0;
  logic prev_done = 1'b0;
  logic [6:0] pn_m = 7'h01;
  exp_t sbq[$];

  sar_timeout_ctrl #(.NBITS(NB), .TMO_W(TW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_p_i    (cmp_p),
    .cmp_n_i    (cmp_n),
    .tmo_limit_i(limit),
    .cmp_clk_o  (cmp_clk),
    .dac_o      (dac),
    .done_o     (done),
    .result_o   (result),
    .tmo_flag_o (tflag)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int low_idx(input logic [NB-1:0] v);
    int r = 0;
    for (int k = NB - 1; k >= 0; k--) if (v[k]) r = k;
    return r;
  endfunction

  // Comparator model: both outputs high while its clock is low.
  always @(negedge clk) begin
    if (!cmp_clk) begin
      hicnt = 0;
      cmp_p = 1'b1;
      cmp_n = 1'b1;
    end else begin
      int t;
      int d;
      hicnt++;
      t = low_idx(dac);
      d = stuck[t] ? 100000 : dly_base;
      if (hicnt >= d) begin
        cmp_n = !(vin >= int'(dac));
        cmp_p = (vin >= int'(dac));
      end
    end
  end

  // Phase monitor and scoreboard.
  always @(negedge clk) begin
    if (cmp_clk) begin
      cur++;
    end else if (cur > 0) begin
      if (ph < NB) hl[ph] = cur;
      ph++;
      cur = 0;
    end
    if (done) begin
      ndone++;
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(result == e.res, {"R4 result ", e.tag}, int'(result), int'(e.res));
        chk(tflag == e.flg, {"R6 flag ", e.tag}, int'(tflag), int'(e.flg));
      end
      if (prev_done) chk(1'b0, "R10 done width", 2, 1);
    end
    prev_done = done;
  end

  task automatic convert(input int v, input int lim, input int base,
                         input logic [NB-1:0] stk, input bit restart, input string tag);
    exp_t e;
    logic [NB-1:0] decd = '0;
    logic f = 1'b0;
    int nd0;
    int w = 0;
    vin = v;
    limit = TW'(lim);
    dly_base = base;
    stuck = stk;
    for (int i = NB - 1; i >= 0; i--) begin
      logic [NB-1:0] tr;
      int d;
      logic b;
      tr = decd | (NB'(1) << i);
      d = stk[i] ? 100000 : base;
      if (lim != 0 && d > lim) begin
        b = pn_m[6];
        pn_m = {pn_m[5:0], pn_m[6] ^ pn_m[5]};
        f = 1'b1;
      end else begin
        b = (v >= int'(tr));
      end
      if (b) decd = decd | (NB'(1) << i);
    end
    e.res = decd;
    e.flg = f;
    e.tag = tag;
    sbq.push_back(e);
    ph = 0;
    cur = 0;
    nd0 = ndone;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cmp_clk == 1'b1, "R2 clock rises after start", int'(cmp_clk), 1);
    chk(dac == {1'b1, {(NB-1){1'b0}}}, "R2 first trial code", int'(dac), 1 << (NB - 1));
    if (restart) begin
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 20000) chk(1'b0, "R10 done never seen", 0, 1);
    repeat (4) @(negedge clk);
    chk(ph == NB, {"R5 high phases ", tag}, ph, NB);
    for (int i = NB - 1; i >= 0; i--) begin
      int d;
      int el;
      d = stk[i] ? 100000 : base;
      el = (lim != 0 && d > lim) ? lim : d;
      if (NB - 1 - i < ph) chk(hl[NB - 1 - i] == el, {"R6 R8 phase length ", tag}, hl[NB - 1 - i], el);
    end
    chk(ndone == nd0 + 1, {"R11 R10 single done ", tag}, ndone - nd0, 1);
    chk(result == e.res, {"R10 result held ", tag}, int'(result), int'(e.res));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmp_clk == 1'b0 && done == 1'b0, "R1 reset outputs", int'({cmp_clk, done}), 0);
    chk(result == '0 && tflag == 1'b0, "R1 reset result", int'(result), 0);
    chk(dac == '0, "R1 reset dac", int'(dac), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cmp_clk == 1'b0 && dac == '0, "R1 idle after reset", int'(dac), 0);
    // R3 R4: ordinary conversions, fast comparator
    convert(677, 8, 1, '0, 1'b0, "mid code");
    convert(0, 8, 2, '0, 1'b0, "zero");
    convert(1023, 8, 3, '0, 1'b0, "full scale");
    // R7: resolution on the same clock as the limit
    convert(341, 4, 4, '0, 1'b0, "tie");
    // R6 R9: every trial forced
    convert(500, 4, 5, '0, 1'b0, "all forced");
    // R6 R9: forced trials scattered inside a conversion
    convert(612, 3, 1, 10'h050, 1'b0, "mixed");
    // R8: limit zero, slow comparator
    convert(200, 0, 20, '0, 1'b0, "no limit");
    // R11: start during conversion
    convert(901, 6, 2, 10'h004, 1'b1, "restart ignored");
    convert(77, 2, 1, 10'h201, 1'b0, "edge trials forced");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule